// File: doc/BRIEF.md
# PLL Register Controller with Unlock Feed

This block is the register side of a clock-generation PLL. Software writes a pending enable/connect pair and a pending multiplier/divider pair over a small register bus. None of these values reaches the PLL until a two-write unlock pattern is written to the feed register. Only then are the pending values copied into the active set that drives the PLL and the clock-source select. The active values are what software reads back from the status register, and they can differ from the pending ones.

The analog loop is modelled by a lock counter. Lock is lost at once when the active enable drops or when the active frequency settings change. It is regained after a fixed number of clock cycles while the PLL stays enabled. The block does not contain the glitch-free clock multiplexer. It only drives that multiplexer's select line, and the select points at the PLL only while the PLL is enabled, connected and locked.

Top module: `pll_regunit`

## Requirements
- R1: After reset, all pending and active fields read zero, lock is clear, the feed readback is zero and the source select chooses the oscillator (0).
- R2: Address 0 holds the pending control bits, with enable at bit 0 and connect at bit 1. Address 1 holds the pending configuration, with the multiplier in bits 6:0 and the divider in bits 11:7. Both read back at once, and writing them leaves every active output unchanged.
- R3: A feed write (address 3) of 0xAA followed by a feed write of 0x55 copies the pending values to the active set on the clock edge of the 0x55 write. Idle cycles with no bus write may separate the two writes.
- R4: The unlock is aborted by a write to any other address after the 0xAA, or by a feed value other than 0x55 or 0xAA after it, and no commit happens. A further 0xAA re-arms the sequence.
- R5: The active connect bit is set at a commit only if the pending enable is also set. Otherwise it is cleared.
- R6: Address 2 is read-only status: active multiplier in bits 6:0, active divider in bits 11:7, active enable at bit 12, active connect at bit 13 and lock at bit 14.
- R7: Lock rises exactly LOCK_CYCLES clock edges after the commit edge that enabled the PLL, and is never set while the active enable is clear.
- R8: A commit that clears the enable, or that changes the multiplier or the divider, clears lock on that same edge. A commit that changes neither keeps lock.
- R9: The source select is 1 (PLL) exactly when active enable, active connect and lock are all set. Otherwise it is 0 (oscillator).
- R10: Address 3 reads back the last 8-bit value written to the feed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| addr | input | 2 | Register address (0 ctrl, 1 cfg, 2 status, 3 feed) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for addr |
| act_mult | output | 7 | Active multiplier |
| act_div | output | 5 | Active divider |
| act_en | output | 1 | Active PLL enable |
| act_con | output | 1 | Active PLL connect |
| pll_lock | output | 1 | Modelled lock indication |
| src_sel_pll | output | 1 | Clock mux select: 1 PLL, 0 oscillator |

## Verification
A wrongly armed or disarmed unlock state shows on the active outputs and in status on the edge of the next 0x55 feed write, as a commit that should or should not have happened. A lock counter that is off by even one cycle shows at the lock output in the cycle next to the expected rising edge, so lock is sampled on both sides of that edge. A wrong select term shows on src_sel_pll in the same cycle that the active bits or lock change, because the select has no register of its own.

// File: rtl/pll_regunit.sv
module pll_regunit #(
  parameter int MULT_W      = 7,
  parameter int DIV_W       = 5,
  parameter int DATA_W      = 16,
  parameter int LOCK_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [MULT_W-1:0] act_mult,
  output logic [DIV_W-1:0]  act_div,
  output logic              act_en,
  output logic              act_con,
  output logic              pll_lock,
  output logic              src_sel_pll
);
  localparam int CFG_W  = MULT_W + DIV_W;
  localparam int CNT_W  = $clog2(LOCK_CYCLES + 1);
  localparam int STAT_W = CFG_W + 3;
  localparam logic [1:0] A_CTRL = 2'd0, A_CFG = 2'd1, A_STAT = 2'd2, A_FEED = 2'd3;
  localparam logic [7:0] KEY0 = 8'hAA, KEY1 = 8'h55;

  logic             pend_en, pend_con;
  logic [CFG_W-1:0] pend_cfg;
  logic [7:0]       feed_last;
  logic             armed;
  logic [CNT_W-1:0] lock_cnt;

  wire feed_wr = wr_en && addr == A_FEED;
  wire commit  = feed_wr && armed && wdata[7:0] == KEY1;

  wire [MULT_W-1:0] new_mult = pend_cfg[MULT_W-1:0];
  wire [DIV_W-1:0]  new_div  = pend_cfg[CFG_W-1:MULT_W];
  wire relock = commit && (!pend_en || !act_en ||
                           new_mult != act_mult || new_div != act_div);

  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:CFG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_en  <= 1'b0;
      pend_con <= 1'b0;
      pend_cfg <= '0;
    end else if (wr_en) begin
      if (addr == A_CTRL) begin
        pend_en  <= wdata[0];
        pend_con <= wdata[1];
      end
      if (addr == A_CFG) pend_cfg <= wdata[CFG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      feed_last <= 8'h00;
      armed     <= 1'b0;
    end else if (wr_en) begin
      if (feed_wr) begin
        feed_last <= wdata[7:0];
        armed     <= wdata[7:0] == KEY0;
      end else begin
        armed     <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_en   <= 1'b0;
      act_con  <= 1'b0;
      act_mult <= '0;
      act_div  <= '0;
    end else if (commit) begin
      act_en   <= pend_en;
      act_con  <= pend_con && pend_en;
      act_mult <= new_mult;
      act_div  <= new_div;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_cnt <= '0;
      pll_lock <= 1'b0;
    end else if (relock) begin
      lock_cnt <= '0;
      pll_lock <= 1'b0;
    end else if (act_en && !pll_lock) begin
      if (lock_cnt == CNT_W'(LOCK_CYCLES - 1)) pll_lock <= 1'b1;
      else                                     lock_cnt <= lock_cnt + 1'b1;
    end
  end

  assign src_sel_pll = act_en && act_con && pll_lock;

  wire [STAT_W-1:0] status = {pll_lock, act_con, act_en, act_div, act_mult};

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL: rdata[1:0]        = {pend_con, pend_en};
      A_CFG:  rdata[CFG_W-1:0]  = pend_cfg;
      A_STAT: rdata[STAT_W-1:0] = status;
      A_FEED: rdata[7:0]        = feed_last;
    endcase
  end
endmodule

// File: rtl/pll_regunit_chk.sv
module pll_regunit_chk #(
  parameter int MULT_W = 7,
  parameter int DIV_W  = 5,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic [MULT_W-1:0] act_mult,
  input logic [DIV_W-1:0]  act_div,
  input logic              act_en,
  input logic              act_con,
  input logic              pll_lock,
  input logic              src_sel_pll
);
  p_hold_without_feed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 2'd3 && wdata[7:0] == 8'h55)
      |=> $stable(act_en) && $stable(act_con) && $stable(act_mult) && $stable(act_div));

  p_con_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act_con |-> act_en);

  p_lock_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pll_lock |-> act_en);

  p_lock_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_mult) || !$stable(act_div) || $fell(act_en)) |-> !pll_lock);

  p_sel_pll_r9: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel_pll |-> pll_lock && act_con);
endmodule

bind pll_regunit pll_regunit_chk #(.MULT_W(MULT_W), .DIV_W(DIV_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .act_mult(act_mult), .act_div(act_div), .act_en(act_en), .act_con(act_con),
  .pll_lock(pll_lock), .src_sel_pll(src_sel_pll));

// File: tb/pll_regunit_test.sv
module pll_regunit_test;
  localparam int LOCK = 64;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic [6:0]  act_mult;
  logic [4:0]  act_div;
  logic act_en, act_con, pll_lock, src_sel_pll;
  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  pll_regunit #(.LOCK_CYCLES(LOCK)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .act_mult(act_mult), .act_div(act_div), .act_en(act_en),
    .act_con(act_con), .pll_lock(pll_lock), .src_sel_pll(src_sel_pll));

  // {write addr, write data, read addr, expected read, requirement number}
  localparam int NV = 10;
  localparam logic [39:0] VEC [NV] = '{
    {2'd0, 16'h0003, 2'd0, 16'h0003, 4'd2},  // R2 pending ctrl
    {2'd1, 16'h0195, 2'd1, 16'h0195, 4'd2},  // R2 pending cfg
    {2'd3, 16'h00AA, 2'd2, 16'h0000, 4'd3},  // R3 half sequence
    {2'd1, 16'h0195, 2'd2, 16'h0000, 4'd4},  // R4 other write aborts
    {2'd3, 16'h0055, 2'd2, 16'h0000, 4'd4},  // R4 no commit
    {2'd3, 16'h00AA, 2'd3, 16'h00AA, 4'd10}, // R10 feed readback
    {2'd3, 16'h0012, 2'd2, 16'h0000, 4'd4},  // R4 wrong value aborts
    {2'd3, 16'h0055, 2'd3, 16'h0055, 4'd4},  // R4 still no commit
    {2'd3, 16'h00AA, 2'd2, 16'h0000, 4'd3},  // R3 re-arm
    {2'd3, 16'h0055, 2'd2, 16'h3195, 4'd6}   // R6 status after commit
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic feed();
    wr(2'd3, 16'h00AA);
    wr(2'd3, 16'h0055);
  endtask

  task automatic do_reset();
    wr_en = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 outputs", {act_mult, act_div, act_en, act_con, pll_lock, src_sel_pll}, 16'h0);
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #1;
      check("R1 readback", rdata, 16'h0);
    end

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][39:38], VEC[i][37:22]);
      addr = VEC[i][21:20]; #1;
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i), rdata, VEC[i][19:4]);
    end
    wr(2'd0, 16'h0002);
    addr = 2'd2; #1;
    check("R2 active untouched", rdata, 16'h3195);

    do_reset();
    wr(2'd0, 16'h0001); wr(2'd1, 16'h0195); feed();
    check("R3 commit", {act_en, act_con, pll_lock}, 3'b100);
    repeat (LOCK - 1) @(negedge clk);
    check("R7 before lock", pll_lock, 1'b0);
    @(negedge clk);
    check("R7 lock", pll_lock, 1'b1);
    check("R9 not connected", src_sel_pll, 1'b0);

    wr(2'd0, 16'h0003); feed();
    check("R8 lock kept", pll_lock, 1'b1);
    check("R9 pll selected", src_sel_pll, 1'b1);

    wr(2'd1, 16'h0196); feed();
    check("R8 lock cleared", {pll_lock, src_sel_pll}, 2'b00);
    check("R8 new mult", act_mult, 7'h16);
    repeat (LOCK) @(negedge clk);
    check("R8 relock", {pll_lock, src_sel_pll}, 2'b11);

    wr(2'd0, 16'h0002); feed();
    check("R5 connect refused", {act_en, act_con, pll_lock, src_sel_pll}, 4'b0000);

    wr(2'd0, 16'h0003);
    wr(2'd3, 16'h00AA);
    repeat (3) @(negedge clk);
    wr(2'd3, 16'h0055);
    check("R3 idle gap commit", {act_en, act_con}, 2'b11);

    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h00AA); wr(2'd3, 16'h00AA); wr(2'd3, 16'h0055);
    check("R4 repeated key commit", {act_en, act_con}, 2'b00);
    addr = 2'd3; #1;
    check("R10 last feed", rdata, 16'h0055);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule